// File: doc/BRIEF.md
# Hybrid Low-Confidence Fallback Selector

This block produces the final direction for a conditional branch from three sources. The first is a neural predictor whose signed output sum and current training threshold arrive from outside. When the magnitude of that sum is too small to trust, the block falls back to a gshare table of 2-bit saturating counters. When the selected gshare counter is itself in one of its two weak states, a pattern table of single bits supplies the direction. That table is addressed by the branch's own recent history.

The block owns all the table state: the 2-bit counters, the global history register, a per-branch history table and the 1-bit pattern table. It updates all of them when a branch commits. A prediction request is answered one cycle later. The answer carries a two-bit code that names the source used, so that the selection can be watched from outside.

Top module: `hybrid_fallback_sel`

## Requirements
- R1: When |sum| is greater than or equal to theta >> FRAC_SHIFT (FRAC_SHIFT = 2 by default), the neural source is used. The predicted direction is taken exactly when sum >= 0, and out_src reports 0.
- R2: The trust limit is a strict comparison. A magnitude equal to theta >> FRAC_SHIFT stays with the neural source, and a magnitude one below it falls back. When theta >> FRAC_SHIFT is 0, the neural source is always used.
- R3: On fallback, the gshare counter is read at index pred_pc XOR global history (11 bits). A counter value of 3 predicts taken and 0 predicts not taken, and out_src reports 1. out_src is never 3.
- R4: On fallback with a gshare counter value of 1 or 2, the pattern bit is used as the direction and out_src reports 2. The pattern bit is addressed by the local history held for the branch in the per-branch history table, which is selected by pred_pc[5:0].
- R5: On commit, the gshare counter at cmt_pc XOR global history moves one step toward the outcome and saturates at 0 and at 3. It never wraps.
- R6: On commit, the pattern bit addressed by the branch's pre-commit local history is written with the outcome. The outcome is then shifted in at bit 0 of both that local history and the global history. Neither history changes without a commit.
- R7: out_valid is high exactly one cycle after pred_valid. A prediction made in the same cycle as a commit sees the state from before that commit.
- R8: After reset, every gshare counter is 1 (weak not-taken), every pattern bit is 0, all histories are 0, and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_valid | input | 1 | Prediction request |
| pred_pc | input | PC_W (11) | Low branch address bits of the request |
| pred_sum | input | SUM_W (16) | Signed neural output |
| pred_theta | input | THETA_W (12) | Current neural training threshold |
| cmt_valid | input | 1 | A branch commits this cycle |
| cmt_pc | input | PC_W (11) | Low branch address bits of the committing branch |
| cmt_taken | input | 1 | Resolved outcome of the committing branch |
| out_valid | output | 1 | Prediction result valid |
| out_taken | output | 1 | Predicted direction |
| out_src | output | 2 | Source used: 0 neural, 1 gshare, 2 local |

## Verification
On every cycle, the assertions check the following:
- the response one cycle after each request;
- the sign rule on neural picks;
- that the source code is legal;
- the saturation of a strong counter;
- that the global history is frozen without a commit;
- that a commit's outcome lands at bit 0 of the local history.

Only the bench's reference model can show that the whole cascade chooses correctly. This covers the threshold equality case and the fallback into the weak-counter region. It also covers the effect of trained state on later predictions, such as a pattern bit written under one history and read back once that history recurs.

// File: rtl/fbsel_pkg.sv
// Package: shared types and helpers for the hybrid fallback selector.
// Assumes two-bit saturating counters and a three-way source code.
package fbsel_pkg;

    typedef enum logic [1:0] {
        SRC_NEURAL = 2'd0,
        SRC_GSHARE = 2'd1,
        SRC_LOCAL  = 2'd2
    } src_e;

    localparam logic [1:0] CTR_MAX  = 2'd3;
    localparam logic [1:0] CTR_MIN  = 2'd0;
    localparam logic [1:0] CTR_INIT = 2'd1;

    // One saturating step of a 2-bit counter toward the outcome.
    function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
        logic [1:0] n;
        if (up) n = (c == CTR_MAX) ? c : c + 2'd1;
        else    n = (c == CTR_MIN) ? c : c - 2'd1;
        return n;
    endfunction

    // A counter is confident only at either end of its range.
    function automatic logic ctr_strong(input logic [1:0] c);
        return (c == CTR_MAX) || (c == CTR_MIN);
    endfunction

endpackage

// File: rtl/fb_gshare_tbl.sv
// Module: gshare counter table plus the global history register.
// Reads are combinational at pc XOR history. A commit updates the counter
// addressed with the pre-commit history and then shifts the outcome in.
// Assumes the address width equals the history width.
module fb_gshare_tbl
    import fbsel_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_pc,
    output logic [1:0]       rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_pc,
    input  logic             wr_taken
);
    localparam int DEPTH = 1 << IDX_W;

    logic [1:0]       ctr_q [DEPTH];
    logic [IDX_W-1:0] ghr_q;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;

    // Hash both addresses with the current global history.
    always_comb begin
        rd_idx = rd_pc ^ ghr_q;
        wr_idx = wr_pc ^ ghr_q;
        rd_ctr = ctr_q[rd_idx];
    end

    // Reset or train the counters and shift the global history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
            ghr_q <= '0;
        end else if (wr_en) begin
            ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
            ghr_q         <= {ghr_q[IDX_W-2:0], wr_taken};
        end
    end

    // R5: a strong counter pushed further stays at its end
    p_ctr_hold_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && ctr_q[wr_idx] == CTR_MAX) |=> (ctr_q[$past(wr_idx)] == CTR_MAX));
    p_ctr_hold_bot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && ctr_q[wr_idx] == CTR_MIN) |=> (ctr_q[$past(wr_idx)] == CTR_MIN));
    // R6: global history moves only on commit
    p_ghr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ghr_q));

endmodule

// File: rtl/fb_local_tbl.sv
// Module: per-branch history table and the 1-bit pattern table it addresses.
// A read returns the pattern bit at the branch's current local history. A
// commit writes the outcome at the pre-commit history and then shifts it in.
module fb_local_tbl #(
    parameter int LHT_IDX_W = 6,
    parameter int HIST_W    = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LHT_IDX_W-1:0] rd_sel,
    output logic                 rd_bit,
    input  logic                 wr_en,
    input  logic [LHT_IDX_W-1:0] wr_sel,
    input  logic                 wr_taken
);
    localparam int LHT_DEPTH = 1 << LHT_IDX_W;
    localparam int PHT_DEPTH = 1 << HIST_W;

    logic [HIST_W-1:0]    lht_q [LHT_DEPTH];
    logic [PHT_DEPTH-1:0] pht_q;
    logic [HIST_W-1:0]    rd_hist;
    logic [HIST_W-1:0]    wr_hist;

    // Two-level lookup: branch history, then pattern bit.
    always_comb begin
        rd_hist = lht_q[rd_sel];
        wr_hist = lht_q[wr_sel];
        rd_bit  = pht_q[rd_hist];
    end

    // Reset or train the local histories and pattern bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LHT_DEPTH; i++) lht_q[i] <= '0;
            pht_q <= '0;
        end else if (wr_en) begin
            pht_q[wr_hist] <= wr_taken;
            lht_q[wr_sel]  <= {wr_hist[HIST_W-2:0], wr_taken};
        end
    end

    // R6: the newest outcome sits at bit 0 of that branch's local history
    p_lht_newest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (lht_q[$past(wr_sel)][0] == $past(wr_taken)));

endmodule

// File: rtl/fb_select.sv
// Module: combinational cascade that picks the source and direction.
// Neural wins unless |sum| < theta >> FRAC_SHIFT. Gshare wins next unless its
// counter is weak, and the local pattern bit decides last.
module fb_select
    import fbsel_pkg::*;
#(
    parameter int SUM_W      = 16,
    parameter int THETA_W    = 12,
    parameter int FRAC_SHIFT = 2
) (
    input  logic signed [SUM_W-1:0]   sum_i,
    input  logic        [THETA_W-1:0] theta_i,
    input  logic        [1:0]         gsh_ctr_i,
    input  logic                      loc_bit_i,
    output logic                      taken_o,
    output src_e                      src_o
);
    localparam int CMP_W = (SUM_W > THETA_W) ? SUM_W : THETA_W;

    logic [SUM_W-1:0] mag;
    logic [CMP_W-1:0] mag_x;
    logic [CMP_W-1:0] lim_x;
    logic             weak_neural;

    // Magnitude of the neural output against the scaled threshold.
    always_comb begin
        mag         = sum_i[SUM_W-1] ? (~sum_i + 1'b1) : sum_i;
        mag_x       = CMP_W'(mag);
        lim_x       = CMP_W'(theta_i >> FRAC_SHIFT);
        weak_neural = mag_x < lim_x;
    end

    // Three-level priority choice of the source.
    always_comb begin
        if (!weak_neural) begin
            src_o   = SRC_NEURAL;
            taken_o = !sum_i[SUM_W-1];
        end else if (ctr_strong(gsh_ctr_i)) begin
            src_o   = SRC_GSHARE;
            taken_o = gsh_ctr_i[1];
        end else begin
            src_o   = SRC_LOCAL;
            taken_o = loc_bit_i;
        end
    end

endmodule

// File: rtl/hybrid_fallback_sel.sv
// Module: top of the hybrid fallback selector.
// Registers one prediction per request, one cycle after pred_valid.
// Predictions read the table state from before any commit in the same cycle.
module hybrid_fallback_sel
    import fbsel_pkg::*;
#(
    parameter int PC_W       = 11,
    parameter int LHT_IDX_W  = 6,
    parameter int LHIST_W    = 11,
    parameter int SUM_W      = 16,
    parameter int THETA_W    = 12,
    parameter int FRAC_SHIFT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pred_valid,
    input  logic [PC_W-1:0]    pred_pc,
    input  logic [SUM_W-1:0]   pred_sum,
    input  logic [THETA_W-1:0] pred_theta,
    input  logic               cmt_valid,
    input  logic [PC_W-1:0]    cmt_pc,
    input  logic               cmt_taken,
    output logic               out_valid,
    output logic               out_taken,
    output logic [1:0]         out_src
);
    logic [1:0] gsh_ctr;
    logic       loc_bit;
    logic       sel_taken;
    src_e       sel_src;

    fb_gshare_tbl #(.IDX_W(PC_W)) gsh_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_pc    (pred_pc),
        .rd_ctr   (gsh_ctr),
        .wr_en    (cmt_valid),
        .wr_pc    (cmt_pc),
        .wr_taken (cmt_taken)
    );

    fb_local_tbl #(.LHT_IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) loc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel   (pred_pc[LHT_IDX_W-1:0]),
        .rd_bit   (loc_bit),
        .wr_en    (cmt_valid),
        .wr_sel   (cmt_pc[LHT_IDX_W-1:0]),
        .wr_taken (cmt_taken)
    );

    fb_select #(.SUM_W(SUM_W), .THETA_W(THETA_W), .FRAC_SHIFT(FRAC_SHIFT)) sel_i (
        .sum_i     (pred_sum),
        .theta_i   (pred_theta),
        .gsh_ctr_i (gsh_ctr),
        .loc_bit_i (loc_bit),
        .taken_o   (sel_taken),
        .src_o     (sel_src)
    );

    // Register the selected prediction for the requester.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_taken <= 1'b0;
            out_src   <= SRC_NEURAL;
        end else begin
            out_valid <= pred_valid;
            out_taken <= pred_valid ? sel_taken : 1'b0;
            out_src   <= pred_valid ? sel_src : SRC_NEURAL;
        end
    end

    // R7: every request is answered one cycle later, and only then
    p_answer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |=> out_valid);
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid |=> !out_valid);
    // R3: the source code is always one of the three defined values
    p_src_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_src != 2'd3));
    // R1: a neural pick follows the sign of the requesting sum
    p_neural_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid ##1 (out_src == SRC_NEURAL)) |-> (out_taken == !$past(pred_sum[SUM_W-1])));

endmodule

// File: tb/hybrid_fallback_sel_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus directed scenarios.
module hybrid_fallback_sel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pred_valid = 1'b0;
    logic [10:0] pred_pc = '0;
    logic [15:0] pred_sum = '0;
    logic [11:0] pred_theta = '0;
    logic        cmt_valid = 1'b0;
    logic [10:0] cmt_pc = '0;
    logic        cmt_taken = 1'b0;
    logic        out_valid;
    logic        out_taken;
    logic [1:0]  out_src;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit run_cmp = 0;
    int hits [3] = '{0, 0, 0};

    // reference state
    int m_ctr [2048];
    bit m_pht [2048];
    int m_lht [64];
    int m_ghr;
    bit exp_valid;
    bit exp_taken;
    int exp_src;

    always #2 clk = ~clk;

    hybrid_fallback_sel dut_i (
        .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc),
        .pred_sum(pred_sum), .pred_theta(pred_theta), .cmt_valid(cmt_valid),
        .cmt_pc(cmt_pc), .cmt_taken(cmt_taken), .out_valid(out_valid),
        .out_taken(out_taken), .out_src(out_src)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // model: reset, predict from old state, then apply commit
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) begin m_ctr[i] = 1; m_pht[i] = 0; end
            for (int i = 0; i < 64; i++) m_lht[i] = 0;
            m_ghr = 0;
            exp_valid = 0;
        end else begin
            exp_valid = pred_valid;
            if (pred_valid) begin
                int s, mag, lim, gi, c;
                s   = int'($signed(pred_sum));
                mag = (s < 0) ? -s : s;
                lim = int'(pred_theta) / 4;
                if (mag >= lim) begin
                    exp_src = 0; exp_taken = (s >= 0);
                end else begin
                    gi = (int'(pred_pc) ^ m_ghr) % 2048;
                    c  = m_ctr[gi];
                    if (c == 3 || c == 0) begin
                        exp_src = 1; exp_taken = (c == 3);
                    end else begin
                        exp_src = 2; exp_taken = m_pht[m_lht[int'(pred_pc) % 64]];
                    end
                end
            end
            if (cmt_valid) begin
                int gi, li;
                gi = (int'(cmt_pc) ^ m_ghr) % 2048;
                if (cmt_taken && m_ctr[gi] < 3) m_ctr[gi]++;
                if (!cmt_taken && m_ctr[gi] > 0) m_ctr[gi]--;
                li = int'(cmt_pc) % 64;
                m_pht[m_lht[li]] = cmt_taken;
                m_lht[li] = ((m_lht[li] << 1) | int'(cmt_taken)) % 2048;
                m_ghr = ((m_ghr << 1) | int'(cmt_taken)) % 2048;
            end
        end
    end

    // per-cycle comparison, half a period after the edge
    always @(negedge clk) begin
        if (run_cmp && rst_n) begin
            check("R7 out_valid", int'(out_valid), int'(exp_valid));
            if (exp_valid) begin
                string tag;
                tag = (exp_src == 0) ? "R1 source" : (exp_src == 1) ? "R3 source" : "R4 source";
                check(tag, int'(out_src), exp_src);
                check(tag, int'(out_taken), int'(exp_taken));
                if (exp_src >= 0 && exp_src < 3) hits[exp_src]++;
            end
        end
    end

    task automatic predict(input int pc, input int sum, input int theta);
        @(negedge clk);
        pred_valid = 1'b1; pred_pc = 11'(pc); pred_sum = 16'(sum); pred_theta = 12'(theta);
        @(negedge clk);
        pred_valid = 1'b0;
    endtask

    task automatic commit(input int pc, input bit t);
        @(negedge clk);
        cmt_valid = 1'b1; cmt_pc = 11'(pc); cmt_taken = t;
        @(negedge clk);
        cmt_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 out_valid after reset", int'(out_valid), 0);
        run_cmp = 1;

        // R8: fresh state, weak counter 1, pattern bit 0 -> local not taken
        predict(5, 0, 400);
        check("R8 reset src", int'(out_src), 2);
        check("R8 reset dir", int'(out_taken), 0);

        // R2: equality stays neural, one below falls back, zero limit always neural
        predict(5, 50, 200);
        check("R2 equal magnitude src", int'(out_src), 0);
        check("R2 equal magnitude dir", int'(out_taken), 1);
        predict(5, -50, 200);
        check("R2 negative equal src", int'(out_src), 0);
        check("R2 negative equal dir", int'(out_taken), 0);
        predict(5, 49, 200);
        check("R2 below limit src", int'(out_src), 2);
        predict(5, 0, 3);
        check("R2 zero limit src", int'(out_src), 0);
        check("R2 zero limit dir", int'(out_taken), 1);
        predict(5, -32768, 4095);
        check("R1 most negative sum src", int'(out_src), 0);
        check("R1 most negative sum dir", int'(out_taken), 0);

        // R5: saturate one counter once the global history is all ones
        for (int k = 0; k < 20; k++) commit('h123, 1'b1);
        predict('h123, 0, 400);
        check("R5 saturated counter src", int'(out_src), 1);
        check("R5 saturated counter dir", int'(out_taken), 1);

        // R6: twelve branches sharing one local-history slot fill it with ones
        for (int k = 1; k <= 12; k++) commit(k * 64, 1'b1);
        predict(64, 0, 400);
        check("R6 pattern bit at recurring history src", int'(out_src), 2);
        check("R6 pattern bit at recurring history dir", int'(out_taken), 1);

        // R7: prediction and commit in the same cycle, then mixed traffic
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            pred_valid = ($urandom_range(0, 3) != 0);
            pred_pc    = 11'($urandom_range(0, 15) * 37);
            pred_sum   = 16'($urandom_range(0, 400) - 200);
            pred_theta = 12'($urandom_range(0, 1023));
            cmt_valid  = ($urandom_range(0, 1) != 0);
            cmt_pc     = 11'($urandom_range(0, 15) * 37);
            cmt_taken  = ($urandom_range(0, 2) != 0);
        end
        @(negedge clk);
        pred_valid = 1'b0; cmt_valid = 1'b0;
        @(negedge clk);

        check("R1 neural source seen", int'(hits[0] > 0), 1);
        check("R3 gshare source seen", int'(hits[1] > 0), 1);
        check("R4 local source seen", int'(hits[2] > 0), 1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule